// File: doc/BRIEF.md
# Transmit Descriptor Ring Walker

This block runs the transmit side of a small set of channels. Each channel owns a circular table of buffer descriptors in a shared descriptor memory. The block reads each descriptor in turn and passes the buffer's pointer and length to a downstream segmentation engine. It waits for that engine to report completion. It then writes the descriptor back so that software owns it again, and moves on to the next entry. Only one channel is serviced at a time.

Software starts a channel with a command strobe. When a fetched descriptor is not yet ready, a per-channel flag selects what happens next:

- With the flag clear, the channel stays in service. It re-reads the descriptor on each pulse of that channel's rate tick.
- With the flag set, the channel is switched off. It stays off until another command arrives.

A descriptor takes two consecutive words, starting at `base + 2*offset`. The first word holds the ready flag, the wrap flag and the buffer length. The second word holds the buffer pointer. Descriptor memory returns read data one cycle after the read strobe.

Top module: `txbd_walker`

## Requirements
- R1: While and after reset, `chan_on` is all zero, and no memory access or buffer handoff takes place until a command arrives.
- R2: A command for an inactive channel sets its `chan_on` bit and starts fetching at word address `base + 2*offset`. The offset is zero after reset. Word 0 holds the ready flag in bit 31, the wrap flag in bit 30 and the length in bits 29:16. Word 1, at the next address, holds the pointer.
- R3: A fetched descriptor with the ready flag set is handed off at once with its pointer, length and channel number. `buf_valid`, `buf_ptr`, `buf_len` and `buf_ch` hold steady until `buf_ready` is seen.
- R4: After `buf_done`, word 0 of the descriptor is written back with bit 31 cleared and every other bit unchanged. The offset then advances by one.
- R5: After a descriptor whose wrap flag is set completes, the offset returns to zero, so the table is used circularly.
- R6: A not-ready descriptor on a channel whose auto-off flag is clear leaves the channel active. The descriptor is fetched again only after a `rate_tick` pulse for that channel, so no handoff occurs before the tick.
- R7: A not-ready descriptor on a channel whose auto-off flag is set clears that channel's `chan_on` bit.
- R8: An inactive channel ignores its rate ticks. A new command restarts it at the descriptor where it stopped, because the offset is kept.
- R9: A command for a channel that is already active has no effect. In particular, it does not trigger an early re-fetch of a polling channel.
- R10: Channels are served one descriptor at a time. When several are eligible, the lowest-numbered one is taken first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_go | input | 1 | Transmit command strobe |
| cmd_ch | input | CW | Channel addressed by the command |
| cfg_base | input | NCH*AW | Table base word address, one field per channel |
| cfg_autooff | input | NCH | Per-channel flag: switch the channel off on a not-ready descriptor |
| mem_rd | output | 1 | Descriptor memory read strobe |
| mem_wr | output | 1 | Descriptor memory write strobe |
| mem_addr | output | AW | Descriptor memory word address |
| mem_wdata | output | 32 | Write-back data |
| mem_rdata | input | 32 | Read data, valid one cycle after `mem_rd` |
| buf_valid | output | 1 | Buffer offer to the segmentation engine |
| buf_ready | input | 1 | Segmentation engine accepts the offer |
| buf_ptr | output | 32 | Buffer pointer |
| buf_len | output | LW | Buffer length |
| buf_ch | output | CW | Channel of the offered buffer |
| buf_done | input | 1 | Pulse: the accepted buffer has been fully sent |
| rate_tick | input | NCH | Per-channel polling tick |
| chan_on | output | NCH | Per-channel active status |

## Verification
The assertions assume that the downstream engine pulses `buf_done` only after it has accepted an offer, and never while an offer is pending. They also assume that memory answers with exactly one cycle of latency and that configuration is static while a channel is active. The bench's memory model returns data on the edge after `mem_rd` and nothing else. Its engine model raises `buf_ready` a few cycles after `buf_valid` and pulses `buf_done` later still. Bases and flags are set before the first command and never change.

// File: rtl/txbd_walker.sv
module txbd_walker #(
  parameter int NCH = 4,
  parameter int AW  = 8,
  parameter int LW  = 14,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cmd_go,
  input  logic [CW-1:0]   cmd_ch,
  input  logic [NCH*AW-1:0] cfg_base,
  input  logic [NCH-1:0]  cfg_autooff,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic [AW-1:0]   mem_addr,
  output logic [31:0]     mem_wdata,
  input  logic [31:0]     mem_rdata,
  output logic            buf_valid,
  input  logic            buf_ready,
  output logic [31:0]     buf_ptr,
  output logic [LW-1:0]   buf_len,
  output logic [CW-1:0]   buf_ch,
  input  logic            buf_done,
  input  logic [NCH-1:0]  rate_tick,
  output logic [NCH-1:0]  chan_on
);
  typedef enum logic [2:0] {S_IDLE, S_RD0, S_W0, S_RD1, S_W1, S_HAND, S_DONE, S_WB} st_t;

  st_t               st;
  logic [CW-1:0]     cur;
  logic [31:0]       desc, ptr;
  logic [NCH-1:0]    act, hold;
  logic [AW-2:0]     offs [NCH];
  logic [AW-1:0]     bases [NCH];
  logic              found;
  logic [CW-1:0]     pick;

  for (genvar g = 0; g < NCH; g++) begin : g_base
    assign bases[g] = cfg_base[g*AW +: AW];
  end

  wire [NCH-1:0] elig   = act & ~hold;
  wire [AW-1:0]  d_addr = bases[cur] + {offs[cur], 1'b0};

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int i = NCH - 1; i >= 0; i--)
      if (elig[i]) begin
        found = 1'b1;
        pick  = CW'(i);
      end
  end

  assign mem_rd    = (st == S_RD0) || (st == S_RD1);
  assign mem_wr    = (st == S_WB);
  assign mem_addr  = (st == S_RD1) ? d_addr + 1'b1 : d_addr;
  assign mem_wdata = {1'b0, desc[30:0]};
  assign buf_valid = (st == S_HAND);
  assign buf_ptr   = ptr;
  assign buf_len   = desc[16 +: LW];
  assign buf_ch    = cur;
  assign chan_on   = act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_IDLE;
      cur  <= '0;
      desc <= '0;
      ptr  <= '0;
      act  <= '0;
      hold <= '0;
      for (int i = 0; i < NCH; i++) offs[i] <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        if (rate_tick[i]) hold[i] <= 1'b0;
        if (cmd_go && cmd_ch == CW'(i) && !act[i]) begin
          act[i]  <= 1'b1;
          hold[i] <= 1'b0;
        end
      end
      case (st)
        S_IDLE: if (found) begin
          cur <= pick;
          st  <= S_RD0;
        end
        S_RD0: st <= S_W0;
        S_W0: begin
          desc <= mem_rdata;
          if (mem_rdata[31]) st <= S_RD1;
          else begin
            st <= S_IDLE;
            if (cfg_autooff[cur]) act[cur] <= 1'b0;
            else hold[cur] <= 1'b1;
          end
        end
        S_RD1: st <= S_W1;
        S_W1: begin
          ptr <= mem_rdata;
          st  <= S_HAND;
        end
        S_HAND: if (buf_ready) st <= S_DONE;
        S_DONE: if (buf_done) st <= S_WB;
        S_WB: begin
          offs[cur] <= desc[30] ? '0 : offs[cur] + 1'b1;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txbd_walker_chk.sv
module txbd_walker_chk #(
  parameter int NCH = 4,
  parameter int LW  = 14,
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           mem_rd,
  input logic           mem_wr,
  input logic [31:0]    mem_wdata,
  input logic           buf_valid,
  input logic           buf_ready,
  input logic [31:0]    buf_ptr,
  input logic [LW-1:0]  buf_len,
  input logic [CW-1:0]  buf_ch,
  input logic           buf_done,
  input logic [NCH-1:0] chan_on
);
  // R1
  reset_off_chk: assert property (@(posedge clk) !rst_n |-> (chan_on == '0 && !buf_valid && !mem_rd && !mem_wr));

  // R3
  offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_valid && !buf_ready |=> buf_valid && $stable(buf_ptr) && $stable(buf_len) && $stable(buf_ch));

  // R4
  wb_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_wr |-> $past(buf_done));

  // R4
  wb_owner_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_wr |-> !mem_wdata[31]);

  // R7
  offer_active_chk: assert property (@(posedge clk) disable iff (!rst_n) buf_valid |-> chan_on[buf_ch]);

  // R10
  single_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mem_rd, mem_wr, buf_valid}) <= 1);
endmodule

bind txbd_walker txbd_walker_chk #(.NCH(NCH), .LW(LW)) u_chk (.*);

// File: tb/sim_txbd_walker.sv
module sim_txbd_walker;
  localparam int NCH = 4;
  localparam int AW  = 8;
  localparam int LW  = 14;
  localparam int CW  = 2;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cmd_go = 1'b0;
  logic [CW-1:0]   cmd_ch = '0;
  logic [NCH*AW-1:0] cfg_base = {8'hC0, 8'h80, 8'h40, 8'h10};
  logic [NCH-1:0]  cfg_autooff = 4'b0010;
  logic            mem_rd, mem_wr;
  logic [AW-1:0]   mem_addr;
  logic [31:0]     mem_wdata;
  logic [31:0]     mem_rdata = '0;
  logic            buf_valid;
  logic            buf_ready = 1'b0;
  logic [31:0]     buf_ptr;
  logic [LW-1:0]   buf_len;
  logic [CW-1:0]   buf_ch;
  logic            buf_done = 1'b0;
  logic [NCH-1:0]  rate_tick = '0;
  logic [NCH-1:0]  chan_on;

  int errors = 0;
  int checks = 0;
  logic [CW+LW+31:0] expq [$];
  logic [31:0] mem [256];
  logic        sw_we = 1'b0;
  logic [7:0]  sw_addr = '0;
  logic [31:0] sw_data = '0;

  always #10 clk = ~clk;

  txbd_walker #(.NCH(NCH), .AW(AW), .LW(LW)) u0 (.*);

  initial for (int i = 0; i < 256; i++) mem[i] = '0;

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr];
    if (mem_wr) mem[mem_addr] <= mem_wdata;
    if (sw_we) mem[sw_addr] <= sw_data;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic poke(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    sw_we = 1'b1; sw_addr = a; sw_data = d;
    @(negedge clk);
    sw_we = 1'b0;
  endtask

  task automatic put_bd(input logic [7:0] base, input int idx, input bit rdy, input bit wrp,
                        input logic [LW-1:0] len, input logic [31:0] p);
    poke(base + 8'(2*idx), {rdy, wrp, len, 16'h0000});
    poke(base + 8'(2*idx + 1), p);
  endtask

  task automatic expect_buf(input logic [CW-1:0] ch, input logic [31:0] p, input logic [LW-1:0] len);
    expq.push_back({ch, len, p});
  endtask

  task automatic command(input logic [CW-1:0] ch);
    @(negedge clk);
    cmd_go = 1'b1; cmd_ch = ch;
    @(negedge clk);
    cmd_go = 1'b0;
  endtask

  task automatic tick(input int ch);
    @(negedge clk);
    rate_tick[ch] = 1'b1;
    @(negedge clk);
    rate_tick = '0;
  endtask

  task automatic report;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  // monitor and downstream engine model
  initial begin
    forever begin
      @(negedge clk);
      if (buf_valid && !buf_ready) begin
        logic [CW+LW+31:0] got;
        got = {buf_ch, buf_len, buf_ptr};
        settle(2);
        chk(buf_valid && {buf_ch, buf_len, buf_ptr} == got, "R3 offer held",
            64'({buf_ch, buf_len, buf_ptr}), 64'(got));
        if (expq.size() == 0) chk(1'b0, "R6/R8/R9 unexpected handoff", 64'(got), 64'd0);
        else begin
          logic [CW+LW+31:0] e;
          e = expq.pop_front();
          chk(got == e, "R3/R10 handoff", 64'(got), 64'(e));
        end
        buf_ready = 1'b1;
        @(negedge clk);
        buf_ready = 1'b0;
        settle(3);
        buf_done = 1'b1;
        @(negedge clk);
        buf_done = 1'b0;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    report();
    $finish;
  end

  initial begin
    settle(3);
    // R1
    chk(chan_on == '0, "R1 chan_on", 64'(chan_on), 64'd0);
    chk(!buf_valid && !mem_rd && !mem_wr, "R1 quiet", 64'({buf_valid, mem_rd, mem_wr}), 64'd0);
    rst_n = 1'b1;
    settle(5);
    chk(!buf_valid && !mem_rd && chan_on == '0, "R1 idle after reset", 64'({buf_valid, mem_rd, chan_on}), 64'd0);

    // R2 R3 R4: channel 0, three ready descriptors, last one wraps
    put_bd(8'h10, 0, 1, 0, 14'd5,     32'hA000_0000);
    put_bd(8'h10, 1, 1, 0, 14'd100,   32'hA000_1000);
    put_bd(8'h10, 2, 1, 1, 14'h3FFF,  32'hA000_2000);
    expect_buf(0, 32'hA000_0000, 14'd5);
    expect_buf(0, 32'hA000_1000, 14'd100);
    expect_buf(0, 32'hA000_2000, 14'h3FFF);
    command(0);
    settle(200);
    chk(expq.size() == 0, "R2 all three handed off", 64'(expq.size()), 64'd0);
    chk(mem[8'h10] == {2'b00, 14'd5, 16'h0}, "R4 writeback d0", 64'(mem[8'h10]), 64'({2'b00, 14'd5, 16'h0}));
    chk(mem[8'h14] == {2'b01, 14'h3FFF, 16'h0}, "R4 writeback d2", 64'(mem[8'h14]), 64'({2'b01, 14'h3FFF, 16'h0}));
    // R6 channel stays active while polling
    chk(chan_on[0], "R6 still active", 64'(chan_on), 64'd1);

    // R5 R6: after wrap, offset 0 is next; idx3 must never be taken
    put_bd(8'h10, 3, 1, 0, 14'd9, 32'hBAD0_0000);
    put_bd(8'h10, 0, 1, 0, 14'd7, 32'hA000_3000);
    settle(50);
    expect_buf(0, 32'hA000_3000, 14'd7);
    tick(0);
    settle(100);
    chk(expq.size() == 0, "R5 wrap to first descriptor", 64'(expq.size()), 64'd0);

    // R9: command on an active polling channel does nothing
    put_bd(8'h10, 1, 1, 0, 14'd33, 32'hA000_4000);
    command(0);
    settle(50);
    chk(chan_on[0], "R9 still active", 64'(chan_on), 64'd1);
    expect_buf(0, 32'hA000_4000, 14'd33);
    tick(0);
    settle(100);
    chk(expq.size() == 0, "R9 resumed only on tick", 64'(expq.size()), 64'd0);

    // R7 R8: channel 1 with auto-off
    put_bd(8'h40, 0, 1, 0, 14'd12, 32'hC100_0000);
    expect_buf(1, 32'hC100_0000, 14'd12);
    command(1);
    settle(100);
    chk(expq.size() == 0, "R7 first buffer sent", 64'(expq.size()), 64'd0);
    chk(!chan_on[1], "R7 deactivated", 64'(chan_on), 64'd0);
    put_bd(8'h40, 1, 1, 0, 14'd44, 32'hC100_1000);
    tick(1);
    settle(50);
    chk(!chan_on[1], "R8 tick ignored while off", 64'(chan_on[1]), 64'd0);
    expect_buf(1, 32'hC100_1000, 14'd44);
    command(1);
    settle(100);
    chk(expq.size() == 0, "R8 resume at stopped descriptor", 64'(expq.size()), 64'd0);
    chk(!chan_on[1], "R7 off again", 64'(chan_on[1]), 64'd0);

    // R10: ch3 and ch2 become eligible while ch0 is busy; lower number goes first
    poke(8'h16, 32'h0);
    put_bd(8'h10, 2, 1, 0, 14'd2, 32'hA000_5000);
    put_bd(8'hC0, 0, 1, 0, 14'd3, 32'hC300_0000);
    put_bd(8'h80, 0, 1, 0, 14'd4, 32'hC200_0000);
    expect_buf(0, 32'hA000_5000, 14'd2);
    expect_buf(2, 32'hC200_0000, 14'd4);
    expect_buf(3, 32'hC300_0000, 14'd3);
    tick(0);
    command(3);
    command(2);
    settle(200);
    chk(expq.size() == 0, "R10 order drained", 64'(expq.size()), 64'd0);
    chk(chan_on == 4'b1101, "R10 channels active", 64'(chan_on), 64'hD);

    report();
    $finish;
  end
endmodule